// File: doc/BRIEF.md
# Instrument Status and Service-Request Core

This block gathers the status of a bus-controlled instrument and decides when to ask the bus controller for service. Four instrument conditions (ramp finished, internal error, alarm, fresh input data) arrive as single-cycle pulses. Each one latches a bit in an 8-bit status byte. A second 8-bit register collects standard bus events: power-on, command error, execution error, device-dependent error, query error and operation complete. Each of these also arrives as a pulse and stays latched. An event enable mask folds the enabled events into one summary bit of the status byte.

A request enable mask chooses which status bits may raise the active-low service-request line. Bit 6 of that mask is a master switch. The host has two ways to read the status byte. The status byte output can be read at any time without side effects; this is the status query. A serial-poll strobe returns the same byte and clears the latched condition bits. A separate strobe reads the event register and clears it.

Top module: `svc_status_core`

## Requirements
- R1: While reset is held and right after it, the status byte reads 0x00, the request line is high and both masks are zero. On the first clock after the internal reset is released, event bit 7 (power-on) becomes 1 and the event register reads 0x80.
- R2: A pulse on `ramp_done_i`, `inst_err_i`, `alarm_i` or `new_data_i` sets status bit 7, 4, 3 or 0 respectively on the next clock. The bit stays set until a serial poll clears it.
- R3: `srq_n_o` is low exactly when request mask bit 6 is 1 and at least one of status bits 7, 5, 4, 3, 0 is set with its matching request mask bit at 1.
- R4: A serial-poll strobe (`poll_i`) clears status bits 7, 4, 3 and 0 on the next clock.
- R5: Reading `status_o` without a poll changes nothing. Status bit 6 reads 1 exactly while the request is active. Status bits 2 and 1 always read 0.
- R6: Pulses on `evt_pulse_i` bits 7, 5, 4, 3, 2, 0 latch the matching event bits. Bits 6 and 1 are ignored and always read 0.
- R7: Status bit 5 is 1 exactly when some event bit is set whose matching event mask bit is 1.
- R8: An event-read strobe (`evt_rd_i`) clears the event register on the next clock. Any event pulse that arrives in the same cycle is kept.
- R9: When a condition pulse and a serial poll occur in the same cycle, the condition's status bit remains set after the poll.
- R10: A write strobe loads its full 8-bit mask on the next clock; `evmask_we_i` loads the event mask and `reqmask_we_i` loads the request mask. If request mask bit 6 is 0, the status byte still updates but `srq_n_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ramp_done_i | input | 1 | Ramp-finished pulse (status bit 7) |
| inst_err_i | input | 1 | Instrument error pulse (status bit 4) |
| alarm_i | input | 1 | Alarm pulse (status bit 3) |
| new_data_i | input | 1 | New input data pulse (status bit 0) |
| evt_pulse_i | input | 8 | Standard event pulses, one per event bit |
| evt_rd_i | input | 1 | Event register read strobe; clears the register |
| evmask_we_i | input | 1 | Event enable mask write strobe |
| evmask_wdata_i | input | 8 | Event enable mask write value |
| reqmask_we_i | input | 1 | Request enable mask write strobe |
| reqmask_wdata_i | input | 8 | Request enable mask write value |
| poll_i | input | 1 | Serial-poll strobe; clears latched status bits |
| status_o | output | 8 | Current status byte (status query view) |
| evt_rdata_o | output | 8 | Current event register |
| srq_n_o | output | 1 | Active-low service request |

## Verification
Two pairs of actions can fall in the same cycle: a condition pulse with a serial poll, and an event pulse with an event-register read. In each pair, the set must win over the clear. The bench forces both collisions in directed cycles and also lets them happen often under random stimulus. After the clock, it compares the status byte and the event register against a bench model in which the set has priority. Mask writes that land in the same cycle as the bits they gate are checked through `srq_n_o` against the same model.

// File: rtl/svc_status_pkg.sv
package svc_status_pkg;
  localparam int BYTE_W = 8;
  // status byte bit positions
  localparam int SB_DATA  = 0;
  localparam int SB_ALARM = 3;
  localparam int SB_ERR   = 4;
  localparam int SB_SUM   = 5;
  localparam int SB_REQ   = 6;
  localparam int SB_RAMP  = 7;
  // event register bit positions that carry behaviour
  localparam int EV_PON   = 7;
  // implemented event bits: 7,5,4,3,2,0
  localparam logic [BYTE_W-1:0] EV_LIVE    = 8'hBD;
  // latched condition bits of the status byte: 7,4,3,0
  localparam logic [BYTE_W-1:0] SB_LATCHED = 8'h99;
  // status bits that may raise a request: 7,5,4,3,0
  localparam logic [BYTE_W-1:0] SB_REQ_SRC = 8'hB9;
endpackage

// File: rtl/svc_rst_sync.sv
module svc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[s] <= 1'b0;
          else          sync_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[s] <= 1'b0;
          else          sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/svc_mask_regs.sv
module svc_mask_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evmask_we_i,
  input  logic [W-1:0] evmask_wdata_i,
  input  logic         reqmask_we_i,
  input  logic [W-1:0] reqmask_wdata_i,
  output logic [W-1:0] evmask_o,
  output logic [W-1:0] reqmask_o
);
  logic [W-1:0] evmask_q, evmask_d;
  logic [W-1:0] reqmask_q, reqmask_d;

  always_comb begin
    evmask_d  = evmask_q;
    reqmask_d = reqmask_q;
    if (evmask_we_i)  evmask_d  = evmask_wdata_i;
    if (reqmask_we_i) reqmask_d = reqmask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evmask_q  <= '0;
      reqmask_q <= '0;
    end else begin
      evmask_q  <= evmask_d;
      reqmask_q <= reqmask_d;
    end
  end

  assign evmask_o  = evmask_q;
  assign reqmask_o = reqmask_q;
endmodule

// File: rtl/svc_event_reg.sv
module svc_event_reg
  import svc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pulse_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] mask_i,
  output logic [BYTE_W-1:0] evt_o,
  output logic              summary_o
);
  logic [BYTE_W-1:0] ev_q, ev_d;
  logic              boot_q, boot_d;
  logic [BYTE_W-1:0] pon_vec;

  always_comb begin
    pon_vec         = '0;
    pon_vec[EV_PON] = boot_q;
    boot_d          = 1'b0;
    // a pulse landing in the clear cycle survives the clear
    ev_d = ((ev_q & {BYTE_W{~rd_i}}) | pulse_i | pon_vec) & EV_LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      boot_q <= 1'b1;
    end else begin
      ev_q   <= ev_d;
      boot_q <= boot_d;
    end
  end

  assign evt_o     = ev_q;
  assign summary_o = |(ev_q & mask_i);
endmodule

// File: rtl/svc_status_byte.sv
module svc_status_byte
  import svc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cond_i,
  input  logic              poll_i,
  input  logic              sum_i,
  input  logic [BYTE_W-1:0] reqmask_i,
  output logic [BYTE_W-1:0] stat_o,
  output logic              req_o
);
  logic [BYTE_W-1:0] lat_q, lat_d;
  logic [BYTE_W-1:0] base;
  logic              req;

  always_comb begin
    // new condition takes priority over the poll clear
    lat_d = ((lat_q & {BYTE_W{~poll_i}}) | cond_i) & SB_LATCHED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  always_comb begin
    base         = lat_q;
    base[SB_SUM] = sum_i;
    req          = reqmask_i[SB_REQ] & |(base & reqmask_i & SB_REQ_SRC);
    stat_o       = base;
    stat_o[SB_REQ] = req;
  end

  assign req_o = req;
endmodule

// File: rtl/svc_status_core.sv
module svc_status_core
  import svc_status_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ramp_done_i,
  input  logic              inst_err_i,
  input  logic              alarm_i,
  input  logic              new_data_i,
  input  logic [BYTE_W-1:0] evt_pulse_i,
  input  logic              evt_rd_i,
  input  logic              evmask_we_i,
  input  logic [BYTE_W-1:0] evmask_wdata_i,
  input  logic              reqmask_we_i,
  input  logic [BYTE_W-1:0] reqmask_wdata_i,
  input  logic              poll_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] evt_rdata_o,
  output logic              srq_n_o
);
  logic              rst_n_s;
  logic [BYTE_W-1:0] evmask_w, reqmask_w;
  logic [BYTE_W-1:0] cond_vec;
  logic              sum_w, req_w;

  svc_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  svc_mask_regs #(.W(BYTE_W)) masks_i (
    .clk(clk), .rst_n(rst_n_s),
    .evmask_we_i(evmask_we_i), .evmask_wdata_i(evmask_wdata_i),
    .reqmask_we_i(reqmask_we_i), .reqmask_wdata_i(reqmask_wdata_i),
    .evmask_o(evmask_w), .reqmask_o(reqmask_w)
  );

  always_comb begin
    cond_vec           = '0;
    cond_vec[SB_RAMP]  = ramp_done_i;
    cond_vec[SB_ERR]   = inst_err_i;
    cond_vec[SB_ALARM] = alarm_i;
    cond_vec[SB_DATA]  = new_data_i;
  end

  svc_event_reg evreg_i (
    .clk(clk), .rst_n(rst_n_s),
    .pulse_i(evt_pulse_i), .rd_i(evt_rd_i), .mask_i(evmask_w),
    .evt_o(evt_rdata_o), .summary_o(sum_w)
  );

  svc_status_byte sbyte_i (
    .clk(clk), .rst_n(rst_n_s),
    .cond_i(cond_vec), .poll_i(poll_i), .sum_i(sum_w),
    .reqmask_i(reqmask_w), .stat_o(status_o), .req_o(req_w)
  );

  assign srq_n_o = ~req_w;
endmodule

// File: rtl/svc_status_chk.sv
module svc_status_chk (
  input logic       clk,
  input logic       rst_n_s,
  input logic       new_data_i,
  input logic       ramp_done_i,
  input logic       inst_err_i,
  input logic       alarm_i,
  input logic       poll_i,
  input logic       evt_rd_i,
  input logic [7:0] evt_pulse_i,
  input logic [7:0] status_o,
  input logic [7:0] evt_rdata_o,
  input logic [7:0] reqmask_w,
  input logic       srq_n_o
);
  logic started_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) started_q <= 1'b0;
    else          started_q <= 1'b1;
  end

  // R3: no request without the master enable
  a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n_s)
    !reqmask_w[6] |-> srq_n_o);

  // R4: a poll with no new condition leaves the latched bits cleared
  a_r4_poll_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (poll_i && !ramp_done_i && !inst_err_i && !alarm_i && !new_data_i)
    |=> (status_o[7] == 1'b0 && status_o[4] == 1'b0 &&
         status_o[3] == 1'b0 && status_o[0] == 1'b0));

  // R9: a new data pulse survives a poll in the same cycle
  a_r9_cond_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    new_data_i |=> status_o[0]);

  // R5 and R6: unused bits stay zero
  a_r5_unused_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    status_o[2:1] == 2'b00 && evt_rdata_o[6] == 1'b0 && evt_rdata_o[1] == 1'b0);

  // R8: a read with no new event empties the register
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (started_q && evt_rd_i && evt_pulse_i == 8'h00) |=> evt_rdata_o == 8'h00);

  // R5: status bit 6 mirrors the request line
  a_r5_req_bit: assert property (@(posedge clk) disable iff (!rst_n_s)
    status_o[6] != srq_n_o);
endmodule

bind svc_status_core svc_status_chk chk_i (
  .clk(clk), .rst_n_s(rst_n_s),
  .new_data_i(new_data_i), .ramp_done_i(ramp_done_i),
  .inst_err_i(inst_err_i), .alarm_i(alarm_i),
  .poll_i(poll_i), .evt_rd_i(evt_rd_i), .evt_pulse_i(evt_pulse_i),
  .status_o(status_o), .evt_rdata_o(evt_rdata_o),
  .reqmask_w(reqmask_w), .srq_n_o(srq_n_o)
);

// File: tb/svc_status_core_tb.sv
module svc_status_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ramp_done_i, inst_err_i, alarm_i, new_data_i;
  logic [7:0] evt_pulse_i;
  logic       evt_rd_i, evmask_we_i, reqmask_we_i, poll_i;
  logic [7:0] evmask_wdata_i, reqmask_wdata_i;
  logic [7:0] status_o, evt_rdata_o;
  logic       srq_n_o;

  svc_status_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .ramp_done_i(ramp_done_i), .inst_err_i(inst_err_i),
    .alarm_i(alarm_i), .new_data_i(new_data_i),
    .evt_pulse_i(evt_pulse_i), .evt_rd_i(evt_rd_i),
    .evmask_we_i(evmask_we_i), .evmask_wdata_i(evmask_wdata_i),
    .reqmask_we_i(reqmask_we_i), .reqmask_wdata_i(reqmask_wdata_i),
    .poll_i(poll_i), .status_o(status_o), .evt_rdata_o(evt_rdata_o),
    .srq_n_o(srq_n_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_lat, m_ev, m_evm, m_rqm;

  function automatic logic [7:0] base_byte(logic [7:0] lat, logic [7:0] ev, logic [7:0] evm);
    logic [7:0] b;
    b    = lat & 8'h99;
    b[5] = |(ev & evm);
    return b;
  endfunction

  function automatic logic exp_req(logic [7:0] lat, logic [7:0] ev, logic [7:0] evm, logic [7:0] rqm);
    return rqm[6] && ((base_byte(lat, ev, evm) & rqm & 8'hB9) != 8'h00);
  endfunction

  function automatic logic [7:0] exp_status(logic [7:0] lat, logic [7:0] ev, logic [7:0] evm, logic [7:0] rqm);
    logic [7:0] s;
    s    = base_byte(lat, ev, evm);
    s[6] = exp_req(lat, ev, evm, rqm);
    return s;
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk8({tag, " status R2 R4 R5 R7 R9"}, status_o, exp_status(m_lat, m_ev, m_evm, m_rqm));
    chk8({tag, " event R6 R8"}, evt_rdata_o, m_ev);
    chk8({tag, " srq R3 R10"}, {7'd0, srq_n_o}, {7'd0, ~exp_req(m_lat, m_ev, m_evm, m_rqm)});
  endtask

  // cond = {ramp, err, alarm, data}
  task automatic do_cycle(input string tag, input logic [3:0] cond, input logic [7:0] evp,
                          input logic poll, input logic evrd,
                          input logic emwe, input logic [7:0] emd,
                          input logic rmwe, input logic [7:0] rmd);
    logic [7:0] cbits;
    @(negedge clk);
    check_outputs(tag);
    ramp_done_i = cond[3]; inst_err_i = cond[2]; alarm_i = cond[1]; new_data_i = cond[0];
    evt_pulse_i = evp; poll_i = poll; evt_rd_i = evrd;
    evmask_we_i = emwe; evmask_wdata_i = emd;
    reqmask_we_i = rmwe; reqmask_wdata_i = rmd;
    cbits = {cond[3], 2'b00, cond[2], cond[1], 2'b00, cond[0]};
    @(posedge clk);
    m_lat = ((m_lat & (poll ? 8'h00 : 8'hFF)) | cbits) & 8'h99;
    m_ev  = ((m_ev & (evrd ? 8'h00 : 8'hFF)) | evp) & 8'hBD;
    if (emwe) m_evm = emd;
    if (rmwe) m_rqm = rmd;
  endtask

  task automatic idle(input string tag);
    do_cycle(tag, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    rst_n = 1'b0;
    ramp_done_i = 0; inst_err_i = 0; alarm_i = 0; new_data_i = 0;
    evt_pulse_i = 0; evt_rd_i = 0; poll_i = 0;
    evmask_we_i = 0; evmask_wdata_i = 0; reqmask_we_i = 0; reqmask_wdata_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk8("R1 reset status", status_o, 8'h00);
    chk8("R1 reset event", evt_rdata_o, 8'h00);
    chk8("R1 reset srq", {7'd0, srq_n_o}, 8'h01);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk8("R1 power-on bit", evt_rdata_o, 8'h80);
    chk8("R1 status after reset", status_o, 8'h00);
    m_lat = 8'h00; m_ev = 8'h80; m_evm = 8'h00; m_rqm = 8'h00;

    // R10: masks zero, conditions latch but no request
    do_cycle("R10 no master", 4'hF, 8'h00, 0, 0, 0, 8'h00, 1, 8'hB9);
    idle("R2 latched all");
    do_cycle("R10 enable master", 4'h0, 8'h00, 0, 0, 0, 8'h00, 1, 8'hF9);
    idle("R3 request active");
    // R4: poll clears
    do_cycle("R4 poll", 4'h0, 8'h00, 1, 0, 0, 8'h00, 0, 8'h00);
    idle("R4 after poll");
    // R9: condition and poll collide
    do_cycle("R9 collide", 4'h2, 8'h00, 1, 0, 0, 8'h00, 0, 8'h00);
    idle("R9 alarm kept");
    // R7: summary via event mask, power-on enabled
    do_cycle("R7 mask", 4'h0, 8'h00, 1, 0, 1, 8'h80, 1, 8'h60);
    idle("R7 summary request");
    // R6: unused event bits ignored
    do_cycle("R6 unused", 4'h0, 8'h42, 0, 0, 0, 8'h00, 0, 8'h00);
    idle("R6 unused zero");
    // R8: read clears, same-cycle event kept
    do_cycle("R8 read+event", 4'h0, 8'h04, 0, 1, 1, 8'h04, 0, 8'h00);
    idle("R8 event kept");
    do_cycle("R8 read", 4'h0, 8'h00, 0, 1, 0, 8'h00, 0, 8'h00);
    idle("R8 cleared");
    // R5: query reads repeatedly without clearing
    do_cycle("R5 set data", 4'h1, 8'h00, 0, 0, 0, 8'h00, 1, 8'h41);
    idle("R5 query 1");
    idle("R5 query 2");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] c;
      logic [7:0] e;
      c = 4'h0;
      for (int b = 0; b < 4; b++) if ($urandom % 6 == 0) c[b] = 1'b1;
      e = 8'h00;
      for (int b = 0; b < 8; b++) if ($urandom % 10 == 0) e[b] = 1'b1;
      do_cycle("R2 R3 R4 R8 random", c, e,
               ($urandom % 6) == 0, ($urandom % 8) == 0,
               ($urandom % 16) == 0, 8'($urandom),
               ($urandom % 16) == 0, 8'($urandom));
    end
    idle("random final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule